// File: doc/BRIEF.md
# Flash Access Guard

The flash access guard stands in the path between the bus masters and a flash array. Every request is judged once, and the verdict comes back one clock later. A request carries an address, a kind and a source, and the boot mode of the chip comes with it. The guard compares the request with several protections, each set by a plain configuration input:

- the decoded readout-protection level;
- two execute-only windows;
- a set of write-protected windows;
- a secure boot area made of the lowest flash pages, which can be locked.

The verdict is one of four outcomes: grant, bus error, read error or write-protection error. The guard keeps a sticky flag for each error class, and software clears the flags by writing ones to them.

The secure boot area can be locked by a one-cycle pulse. After that it stays locked until the next reset, so early boot code can seal its own pages before it hands over to the application. An execute-only window serves instruction fetches from the CPU and refuses every other access. The two windows either both apply to the whole memory, or in dual-bank mode each window applies to its own bank only.

Top module: `fap_guard`

## Requirements
- R1: A request with `req_valid` high is answered in the next cycle with `rsp_valid` high and exactly one of `rsp_grant`, `rsp_bus_err`, `rsp_rd_err`, `rsp_wrp_err` high. Kind codes are 0 fetch, 1 data read, 2 program, 3 page erase and 4 mass erase. Kind codes 5 to 7 get a bus error. With no request, all four outcome outputs are low.
- R2: When `cfg_rdp` is nonzero, a request gets a bus error if its source is not the CPU or DMA, or if the boot mode is not flash. Source codes are 0 CPU, 1 DMA and 2 debug. Boot codes are 0 flash, 1 system memory and 2 SRAM. When `cfg_rdp` is 0, a debug access is judged by the other rules.
- R3: Inside an enabled execute-only window (inclusive `lo` and `hi` bounds), a CPU fetch is granted. A data read, or a fetch from DMA or debug, gets a read error, and a program gets a write-protection error.
- R4: A page erase gets a write-protection error if its page (address bits AW-1 to PB) lies between the pages of an enabled execute-only window's start and end addresses, including those end pages.
- R5: A mass erase gets a write-protection error if any execute-only window or any write-protected window is enabled. Otherwise, with the secure area unlocked, it is granted.
- R6: A program inside an enabled write-protected window, or a page erase whose page overlaps one, gets a write-protection error. Reads there are granted.
- R7: A pulse on `sec_lock_set` sets `sec_locked` from the next cycle on, and it stays set until reset. While locked, accesses to the pages below `cfg_sec_pages` behave as follows: a fetch or read gets a read error, a program or page erase gets a write-protection error, and a mass erase is refused. Before the lock these accesses are not affected.
- R8: With `cfg_dual_bank` high, execute-only window 0 applies only to addresses with bit AW-1 clear, and window 1 only to addresses with it set. With `cfg_dual_bank` low, both windows apply everywhere.
- R9: When several checks fail, the verdict comes from the first failing check in this order: bus error, secure area, execute-only, write protection.
- R10: The sticky flags `sticky_bus`, `sticky_rd` and `sticky_wrp` set with their error outputs. A `clr_valid` pulse clears the flags whose `clr_mask` bit is one (bit 0 bus, bit 1 read, bit 2 write-protection). An error that arrives in the same cycle as the clear keeps its flag set.
- R11: After reset, `rsp_valid`, all outcome outputs, all sticky flags and `sec_locked` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| req_valid | input | 1 | request present |
| req_addr | input | AW | byte address |
| req_kind | input | 3 | access kind code |
| req_src | input | 2 | master code |
| req_boot | input | 2 | boot mode code |
| cfg_rdp | input | 2 | decoded readout-protection level |
| cfg_dual_bank | input | 1 | per-bank execute-only windows |
| cfg_xo_en | input | 2 | execute-only window enables |
| cfg_xo_lo | input | 2*AW | window start addresses, window k at bits k*AW |
| cfg_xo_hi | input | 2*AW | window end addresses |
| cfg_wp_en | input | NWP | write-protected window enables |
| cfg_wp_lo | input | NWP*AW | write-protected start addresses |
| cfg_wp_hi | input | NWP*AW | write-protected end addresses |
| cfg_sec_pages | input | AW-PB | number of pages in the secure area |
| sec_lock_set | input | 1 | lock pulse for the secure area |
| clr_valid | input | 1 | sticky-flag clear strobe |
| clr_mask | input | 3 | write-one-to-clear mask |
| rsp_valid | output | 1 | verdict present |
| rsp_grant | output | 1 | access granted |
| rsp_bus_err | output | 1 | bus error |
| rsp_rd_err | output | 1 | read error |
| rsp_wrp_err | output | 1 | write-protection error |
| sticky_bus | output | 1 | sticky bus-error flag |
| sticky_rd | output | 1 | sticky read-error flag |
| sticky_wrp | output | 1 | sticky write-protection flag |
| sec_locked | output | 1 | secure area locked |

## Verification
Two functions can fall into the same clock edge. The first is a write-one-to-clear of a sticky flag, and the second is a new error of the same class. The bench provokes this by raising `clr_valid`, with the write-protection bit in the mask, in the same cycle as a program into a write-protected window. It then expects `sticky_wrp` to remain set, and a clear on its own afterwards to drop the flag. The precedence of errors is judged in a similar way: the bench chooses requests that fail two checks at once, for example a debug read of a locked secure page, or a CPU fetch of an execute-only address that is also secure. It then expects the outcome of the check that comes first in the order.

// File: rtl/fap_pkg.sv
package fap_pkg;
    localparam int NXO = 2;

    typedef enum logic [2:0] {
        K_FETCH  = 3'd0,
        K_READ   = 3'd1,
        K_PROG   = 3'd2,
        K_PERASE = 3'd3,
        K_MERASE = 3'd4
    } kind_e;

    localparam logic [1:0] SRC_CPU    = 2'd0;
    localparam logic [1:0] SRC_DMA    = 2'd1;
    localparam logic [1:0] BOOT_FLASH = 2'd0;

    typedef enum logic [1:0] {
        V_GRANT = 2'd0,
        V_BUS   = 2'd1,
        V_RD    = 2'd2,
        V_WRP   = 2'd3
    } verdict_e;

    localparam int FLAG_BUS = 0;
    localparam int FLAG_RD  = 1;
    localparam int FLAG_WRP = 2;

    typedef struct packed {
        logic     rsp_valid;
        verdict_e verdict;
        logic [2:0] sticky;
        logic     locked;
    } state_t;
endpackage

// File: rtl/fap_window.sv
module fap_window #(
    parameter int AW = 16,
    parameter int PB = 11
) (
    input  logic          en,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic          addr_hit,
    output logic          page_hit
);
    localparam int PW = AW - PB;

    logic [PW-1:0] pg, pg_lo, pg_hi;

    assign pg    = addr[AW-1:PB];
    assign pg_lo = lo[AW-1:PB];
    assign pg_hi = hi[AW-1:PB];

    assign addr_hit = en && (addr >= lo) && (addr <= hi);
    assign page_hit = en && (pg >= pg_lo) && (pg <= pg_hi);
endmodule

// File: rtl/fap_judge.sv
module fap_judge
    import fap_pkg::*;
#(
    parameter int AW  = 16,
    parameter int PB  = 11,
    parameter int NWP = 2,
    localparam int PW = AW - PB
) (
    input  logic [2:0]       kind,
    input  logic [1:0]       src,
    input  logic [1:0]       boot,
    input  logic [1:0]       rdp,
    input  logic             dual,
    input  logic             locked,
    input  logic [PW-1:0]    sec_pages,
    input  logic [AW-1:0]    addr,
    input  logic [NXO-1:0]   xo_en,
    input  logic [NXO*AW-1:0] xo_lo,
    input  logic [NXO*AW-1:0] xo_hi,
    input  logic [NWP-1:0]   wp_en,
    input  logic [NWP*AW-1:0] wp_lo,
    input  logic [NWP*AW-1:0] wp_hi,
    output verdict_e         verdict
);
    logic [NXO-1:0] xo_a, xo_p, xo_bank_ok, xo_touch;
    logic [NWP-1:0] wp_a, wp_p, wp_touch;

    logic is_fetch, is_read, is_prog, is_perase, is_merase, bad_kind;
    logic [PW-1:0] page;

    assign is_fetch  = (kind == K_FETCH);
    assign is_read   = (kind == K_READ);
    assign is_prog   = (kind == K_PROG);
    assign is_perase = (kind == K_PERASE);
    assign is_merase = (kind == K_MERASE);
    assign bad_kind  = !(is_fetch || is_read || is_prog || is_perase || is_merase);
    assign page      = addr[AW-1:PB];

    for (genvar k = 0; k < NXO; k++) begin : g_xo
        localparam logic BANK = (k != 0);
        fap_window #(.AW(AW), .PB(PB)) u_win (
            .en       (xo_en[k]),
            .addr     (addr),
            .lo       (xo_lo[k*AW +: AW]),
            .hi       (xo_hi[k*AW +: AW]),
            .addr_hit (xo_a[k]),
            .page_hit (xo_p[k])
        );
        assign xo_bank_ok[k] = !dual || (addr[AW-1] == BANK);
        assign xo_touch[k]   = xo_bank_ok[k] && (is_perase ? xo_p[k] : xo_a[k]);
    end

    for (genvar k = 0; k < NWP; k++) begin : g_wp
        fap_window #(.AW(AW), .PB(PB)) u_win (
            .en       (wp_en[k]),
            .addr     (addr),
            .lo       (wp_lo[k*AW +: AW]),
            .hi       (wp_hi[k*AW +: AW]),
            .addr_hit (wp_a[k]),
            .page_hit (wp_p[k])
        );
        assign wp_touch[k] = (is_prog && wp_a[k]) || (is_perase && wp_p[k]);
    end

    logic bus_fail, sec_fail, xo_fail, wp_fail, cpu_fetch, reading;

    always_comb begin
        cpu_fetch = is_fetch && (src == SRC_CPU);
        reading   = is_fetch || is_read;
        bus_fail  = bad_kind
                  || ((rdp != 2'd0)
                      && (!(src == SRC_CPU || src == SRC_DMA) || boot != BOOT_FLASH));
        sec_fail  = locked && (sec_pages != '0) && (is_merase || page < sec_pages);
        xo_fail   = is_merase ? (|xo_en) : ((|xo_touch) && !cpu_fetch);
        wp_fail   = is_merase ? (|wp_en) : (|wp_touch);

        if (bus_fail)      verdict = V_BUS;
        else if (sec_fail) verdict = reading ? V_RD : V_WRP;
        else if (xo_fail)  verdict = reading ? V_RD : V_WRP;
        else if (wp_fail)  verdict = V_WRP;
        else               verdict = V_GRANT;
    end
endmodule

// File: rtl/fap_guard.sv
module fap_guard
    import fap_pkg::*;
#(
    parameter int AW  = 16,
    parameter int PB  = 11,
    parameter int NWP = 2,
    localparam int PW = AW - PB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic [2:0]        req_kind,
    input  logic [1:0]        req_src,
    input  logic [1:0]        req_boot,
    input  logic [1:0]        cfg_rdp,
    input  logic              cfg_dual_bank,
    input  logic [1:0]        cfg_xo_en,
    input  logic [2*AW-1:0]   cfg_xo_lo,
    input  logic [2*AW-1:0]   cfg_xo_hi,
    input  logic [NWP-1:0]    cfg_wp_en,
    input  logic [NWP*AW-1:0] cfg_wp_lo,
    input  logic [NWP*AW-1:0] cfg_wp_hi,
    input  logic [PW-1:0]     cfg_sec_pages,
    input  logic              sec_lock_set,
    input  logic              clr_valid,
    input  logic [2:0]        clr_mask,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_bus_err,
    output logic              rsp_rd_err,
    output logic              rsp_wrp_err,
    output logic              sticky_bus,
    output logic              sticky_rd,
    output logic              sticky_wrp,
    output logic              sec_locked
);
    verdict_e verdict_w;
    state_t   s_d, s_q;

    fap_judge #(.AW(AW), .PB(PB), .NWP(NWP)) u_judge (
        .kind      (req_kind),
        .src       (req_src),
        .boot      (req_boot),
        .rdp       (cfg_rdp),
        .dual      (cfg_dual_bank),
        .locked    (s_q.locked),
        .sec_pages (cfg_sec_pages),
        .addr      (req_addr),
        .xo_en     (cfg_xo_en),
        .xo_lo     (cfg_xo_lo),
        .xo_hi     (cfg_xo_hi),
        .wp_en     (cfg_wp_en),
        .wp_lo     (cfg_wp_lo),
        .wp_hi     (cfg_wp_hi),
        .verdict   (verdict_w)
    );

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = req_valid;
        s_d.verdict   = req_valid ? verdict_w : V_GRANT;
        // clear first, so a same-cycle error wins
        if (clr_valid) s_d.sticky = s_q.sticky & ~clr_mask;
        if (req_valid) begin
            case (verdict_w)
                V_BUS:   s_d.sticky[FLAG_BUS] = 1'b1;
                V_RD:    s_d.sticky[FLAG_RD]  = 1'b1;
                V_WRP:   s_d.sticky[FLAG_WRP] = 1'b1;
                default: ;
            endcase
        end
        if (sec_lock_set) s_d.locked = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid   = s_q.rsp_valid;
    assign rsp_grant   = s_q.rsp_valid && (s_q.verdict == V_GRANT);
    assign rsp_bus_err = s_q.rsp_valid && (s_q.verdict == V_BUS);
    assign rsp_rd_err  = s_q.rsp_valid && (s_q.verdict == V_RD);
    assign rsp_wrp_err = s_q.rsp_valid && (s_q.verdict == V_WRP);
    assign sticky_bus  = s_q.sticky[FLAG_BUS];
    assign sticky_rd   = s_q.sticky[FLAG_RD];
    assign sticky_wrp  = s_q.sticky[FLAG_WRP];
    assign sec_locked  = s_q.locked;
endmodule

// File: rtl/fap_guard_chk.sv
module fap_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_src,
    input logic [1:0] cfg_rdp,
    input logic       sec_lock_set,
    input logic       rsp_valid,
    input logic       rsp_grant,
    input logic       rsp_bus_err,
    input logic       rsp_rd_err,
    input logic       rsp_wrp_err,
    input logic       sticky_bus,
    input logic       sticky_rd,
    input logic       sticky_wrp,
    input logic       sec_locked
);
    assert_one_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_grant, rsp_bus_err, rsp_rd_err, rsp_wrp_err}) == 1);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> $countones({rsp_grant, rsp_bus_err, rsp_rd_err, rsp_wrp_err}) == 0);

    assert_req_answered_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R9: bus error outranks every other check
    assert_debug_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_rdp != 2'd0 && req_src == 2'd2) |=> rsp_bus_err);

    assert_lock_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sec_lock_set |=> sec_locked);

    assert_lock_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sec_locked |=> sec_locked);

    assert_sticky_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_bus_err |-> sticky_bus);

    assert_sticky_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rd_err |-> sticky_rd);

    assert_sticky_wrp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wrp_err |-> sticky_wrp);
endmodule

bind fap_guard fap_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_src      (req_src),
    .cfg_rdp      (cfg_rdp),
    .sec_lock_set (sec_lock_set),
    .rsp_valid    (rsp_valid),
    .rsp_grant    (rsp_grant),
    .rsp_bus_err  (rsp_bus_err),
    .rsp_rd_err   (rsp_rd_err),
    .rsp_wrp_err  (rsp_wrp_err),
    .sticky_bus   (sticky_bus),
    .sticky_rd    (sticky_rd),
    .sticky_wrp   (sticky_wrp),
    .sec_locked   (sec_locked)
);

// File: tb/tb_fap_guard.sv
`timescale 1ns/1ps
module tb_fap_guard;
    localparam int AW = 16;
    localparam int PB = 11;
    localparam int NWP = 2;
    localparam int PW = AW - PB;

    // outcome codes used by the bench
    localparam int OK = 0, BUS = 1, RD = 2, WRP = 3;
    // kinds, sources, boots as stated in R1 and R2
    localparam logic [2:0] FETCH = 3'd0, READ = 3'd1, PROG = 3'd2, PERASE = 3'd3, MERASE = 3'd4;
    localparam logic [1:0] CPU = 2'd0, DMA = 2'd1, DBG = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [2:0] req_kind = '0;
    logic [1:0] req_src = '0;
    logic [1:0] req_boot = '0;
    logic [1:0] cfg_rdp = '0;
    logic cfg_dual_bank = 1'b0;
    logic [1:0] cfg_xo_en = '0;
    logic [2*AW-1:0] cfg_xo_lo = '0, cfg_xo_hi = '0;
    logic [NWP-1:0] cfg_wp_en = '0;
    logic [NWP*AW-1:0] cfg_wp_lo = '0, cfg_wp_hi = '0;
    logic [PW-1:0] cfg_sec_pages = '0;
    logic sec_lock_set = 1'b0;
    logic clr_valid = 1'b0;
    logic [2:0] clr_mask = '0;
    logic rsp_valid, rsp_grant, rsp_bus_err, rsp_rd_err, rsp_wrp_err;
    logic sticky_bus, sticky_rd, sticky_wrp, sec_locked;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fap_guard #(.AW(AW), .PB(PB), .NWP(NWP)) dut (.*);

    task automatic chk_bit(input logic got, input logic exp, input string what);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", what, got, exp);
        end
    endtask

    task automatic access(input logic [AW-1:0] a, input logic [2:0] k,
                          input logic [1:0] s, input int exp, input string what);
        logic [4:0] got, want;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_kind = k; req_src = s;
        @(negedge clk);
        req_valid = 1'b0;
        got  = {rsp_valid, rsp_grant, rsp_bus_err, rsp_rd_err, rsp_wrp_err};
        want = {1'b1, exp == OK, exp == BUS, exp == RD, exp == WRP};
        n_vec++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s: addr %h got %b expected %b", what, a, got, want);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic base_cfg();
        cfg_rdp = 2'd0; req_boot = 2'd0; cfg_dual_bank = 1'b0;
        cfg_xo_en = 2'b11;
        cfg_xo_lo = {16'h9000, 16'h2100};
        cfg_xo_hi = {16'h93FF, 16'h29FF};
        cfg_wp_en = 2'b01;
        cfg_wp_lo = {16'hF000, 16'h4000};
        cfg_wp_hi = {16'hF7FF, 16'h4FFF};
        cfg_sec_pages = 5'd2;
    endtask

    task automatic t_reset();
        chk_bit(rsp_valid, 1'b0, "R11 rsp_valid");
        chk_bit(rsp_grant | rsp_bus_err | rsp_rd_err | rsp_wrp_err, 1'b0, "R11 outcomes");
        chk_bit(sticky_bus | sticky_rd | sticky_wrp, 1'b0, "R11 sticky");
        chk_bit(sec_locked, 1'b0, "R11 lock");
        @(negedge clk);
        chk_bit(rsp_valid, 1'b0, "R1 idle no response");
    endtask

    task automatic t_exec_only();
        base_cfg();
        access(16'h2200, FETCH, CPU, OK,  "R3 cpu fetch in xo");
        access(16'h2200, READ,  CPU, RD,  "R3 cpu read in xo");
        access(16'h2100, READ,  DMA, RD,  "R3 dma read at xo start");
        access(16'h29FF, FETCH, DBG, RD,  "R3 debug fetch at xo end");
        access(16'h29FF, PROG,  CPU, WRP, "R3 program in xo");
        access(16'h2A00, READ,  CPU, OK,  "R3 read past xo end");
        access(16'h0000, 3'd5,  CPU, BUS, "R1 undefined kind");
    endtask

    task automatic t_page_erase();
        base_cfg();
        access(16'h2000, PERASE, CPU, WRP, "R4 erase start page");
        access(16'h2FFC, PERASE, CPU, WRP, "R4 erase end page");
        access(16'h3000, PERASE, CPU, OK,  "R4 erase next page");
        access(16'h1800, PERASE, CPU, OK,  "R4 erase page before");
    endtask

    task automatic t_write_prot();
        base_cfg();
        access(16'h4800, PROG,   CPU, WRP, "R6 program in wp");
        access(16'h4FFF, PERASE, CPU, WRP, "R6 erase in wp");
        access(16'h4800, READ,   DMA, OK,  "R6 read in wp");
        access(16'h5000, PERASE, CPU, OK,  "R6 erase after wp");
    endtask

    task automatic t_mass_erase();
        base_cfg();
        access(16'h0000, MERASE, CPU, WRP, "R5 mass erase with zones");
        cfg_wp_en = '0;
        access(16'h0000, MERASE, CPU, WRP, "R5 mass erase xo only");
        cfg_xo_en = '0;
        access(16'h0000, MERASE, CPU, OK,  "R5 mass erase free");
        cfg_wp_en = 2'b10;
        access(16'h0000, MERASE, CPU, WRP, "R5 mass erase wp only");
    endtask

    task automatic t_dual_bank();
        base_cfg();
        cfg_xo_lo[AW +: AW] = 16'h3000;
        cfg_xo_hi[AW +: AW] = 16'h33FF;
        access(16'h3100, READ, CPU, RD, "R8 single bank zone1 anywhere");
        cfg_dual_bank = 1'b1;
        access(16'h3100, READ, CPU, OK, "R8 dual bank zone1 not in bank0");
        access(16'h2200, READ, CPU, RD, "R8 dual bank zone0 in bank0");
        cfg_xo_lo[AW +: AW] = 16'h9000;
        cfg_xo_hi[AW +: AW] = 16'h93FF;
        cfg_xo_lo[0 +: AW]  = 16'h9000;
        cfg_xo_hi[0 +: AW]  = 16'h93FF;
        cfg_xo_en = 2'b01;
        access(16'h9100, READ, CPU, OK, "R8 dual bank zone0 not in bank1");
        cfg_dual_bank = 1'b0;
        access(16'h9100, READ, CPU, RD, "R8 single bank zone0 in bank1");
    endtask

    task automatic t_bus_error();
        base_cfg();
        cfg_rdp = 2'd1;
        access(16'h6000, READ,  DBG, BUS, "R2 debug at level 1");
        access(16'h6000, READ,  CPU, OK,  "R2 cpu flash boot at level 1");
        access(16'h6000, READ,  DMA, OK,  "R2 dma flash boot at level 1");
        req_boot = 2'd2;
        access(16'h6000, FETCH, CPU, BUS, "R2 sram boot at level 1");
        req_boot = 2'd1;
        access(16'h6000, PROG,  CPU, BUS, "R2 sysmem boot at level 1");
        req_boot = 2'd0;
        cfg_rdp = 2'd2;
        access(16'h6000, READ,  DBG, BUS, "R2 debug at level 2");
        access(16'h2200, READ,  DBG, BUS, "R9 bus before xo");
        cfg_rdp = 2'd0;
        access(16'h6000, READ,  DBG, OK,  "R2 debug at level 0");
    endtask

    task automatic t_sticky();
        base_cfg();
        @(negedge clk); clr_valid = 1'b1; clr_mask = 3'b111;
        @(negedge clk); clr_valid = 1'b0;
        chk_bit(sticky_rd, 1'b0, "R10 cleared start");
        access(16'h2200, READ, CPU, RD, "R10 read error");
        chk_bit(sticky_rd, 1'b1, "R10 rd flag set");
        chk_bit(sticky_wrp, 1'b0, "R10 wrp flag untouched");
        @(negedge clk); clr_valid = 1'b1; clr_mask = 3'b010;
        @(negedge clk); clr_valid = 1'b0;
        chk_bit(sticky_rd, 1'b0, "R10 rd flag cleared");
        // clear and new error in the same cycle
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h4800; req_kind = PROG; req_src = CPU;
        clr_valid = 1'b1; clr_mask = 3'b100;
        @(negedge clk);
        req_valid = 1'b0; clr_valid = 1'b0;
        chk_bit(rsp_wrp_err, 1'b1, "R10 wrp response");
        chk_bit(sticky_wrp, 1'b1, "R10 set wins over clear");
        @(negedge clk); clr_valid = 1'b1; clr_mask = 3'b100;
        @(negedge clk); clr_valid = 1'b0;
        chk_bit(sticky_wrp, 1'b0, "R10 wrp cleared alone");
        cfg_rdp = 2'd1;
        access(16'h6000, READ, DBG, BUS, "R10 bus error");
        cfg_rdp = 2'd0;
        chk_bit(sticky_bus, 1'b1, "R10 bus flag set");
    endtask

    task automatic t_secure();
        base_cfg();
        cfg_xo_en = '0; cfg_wp_en = '0;
        access(16'h0800, PROG, CPU, OK, "R7 before lock");
        @(negedge clk); sec_lock_set = 1'b1;
        @(negedge clk); sec_lock_set = 1'b0;
        chk_bit(sec_locked, 1'b1, "R7 lock taken");
        access(16'h0100, FETCH,  CPU, RD,  "R7 fetch locked");
        access(16'h0800, PROG,   CPU, WRP, "R7 program locked");
        access(16'h0000, PERASE, CPU, WRP, "R7 erase locked");
        access(16'h0FFF, READ,   DMA, RD,  "R7 read last secure byte");
        access(16'h1000, READ,   CPU, OK,  "R7 read past secure");
        access(16'h0000, MERASE, CPU, WRP, "R7 mass erase locked");
        cfg_rdp = 2'd1;
        access(16'h0100, READ, DBG, BUS, "R9 bus before secure");
        cfg_rdp = 2'd0;
        cfg_xo_en = 2'b01;
        cfg_xo_lo[0 +: AW] = 16'h0000;
        cfg_xo_hi[0 +: AW] = 16'h00FF;
        access(16'h0010, FETCH, CPU, RD, "R9 secure before xo");
        repeat (5) @(negedge clk);
        chk_bit(sec_locked, 1'b1, "R7 lock held");
        do_reset();
        chk_bit(sec_locked, 1'b0, "R7 reset unlocks");
        access(16'h0800, PROG, CPU, OK, "R7 program after reset");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        base_cfg();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_exec_only();
        t_page_erase();
        t_write_prot();
        t_mass_erase();
        t_dual_bank();
        t_bus_error();
        t_sticky();
        t_secure();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule